// File: doc/BRIEF.md
# Two-Tone FSK Identifier Demodulator

This block recovers a 44-bit tag identifier from a stream of 8-bit amplitude samples taken from a low-frequency reader front end. The tag answers with two carrier sub-frequencies. A cycle of roughly eight samples encodes one half-bit value, and a cycle of roughly ten samples encodes the other. The block slices each sample to one bit and measures the distance between rising edges to label every cycle as short or long. It then turns runs of equal labels into half-bit symbols and finds the non-Manchester start marker. Symbol pairs after the marker are assembled into an identifier register.

Samples enter on a valid/ready stream. `s_ready` drops for one cycle after every accepted sample that completes a cycle. It also stays low while the block is still handing out half-bit symbols from a run, and while a finished identifier waits at the output. A sample counts as accepted only in a cycle where `s_valid` and `s_ready` are both high. Identifiers leave on a second valid/ready stream. While `o_valid` is high and `o_ready` is low, the output holds its value and the whole pipeline freezes, with no sample and no symbol lost. The edge-distance counter saturates at its maximum, so a long gap never wraps around into a short cycle. An active-high synchronous reset clears all stages, and after reset decoding restarts by waiting for the first rising edge.

Top module: `fsk_tag_demod`

## Requirements
- R1: A sample value of 127 or more slices to 1, and any value of 126 or less slices to 0.
- R2: The first rising edge after reset only synchronises the block. Every later rising edge labels the cycle that just ended: a distance of 8 samples or fewer since the previous rising edge is short (half-bit value 1), and any longer distance is long (half-bit value 0).
- R3: When the label changes, the finished run of n equal labels becomes k = (n+1)/6 symbols for short runs and k = (n+1)/5 symbols for long runs, using integer division.
- R4: A value of k equal to 0 or 1 emits one symbol, and a k of 2, 3 or 4 emits k copies. A k of 5 or more emits no symbol at all.
- R5: Six consecutive symbols 1,1,1,0,0,0, read oldest first, form the start marker. The marker is searched at every symbol position while no frame is open, and at every pair boundary while a frame is open.
- R6: Inside a frame, each symbol pair 1,0 shifts a 0 into bit 0 of the 64-bit identifier and each pair 0,1 shifts a 1, with older bits moving up by one. Any other pair closes the frame and clears the identifier.
- R7: When a marker is found and the identifier is nonzero, the identifier is presented on `o_id` with `o_card` equal to identifier bits 16 down to 1, and the register is then cleared. A zero identifier produces no output.
- R8: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_id` and `o_card` hold steady and `s_ready` stays low.
- R9: Reset drives `o_valid` low and `s_ready` high, and it discards any partly collected identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_data | input | DATA_W (8) | Amplitude sample |
| o_valid | output | 1 | Identifier valid |
| o_ready | input | 1 | Identifier consumer ready |
| o_id | output | ID_W (64) | Recovered identifier |
| o_card | output | CARD_W (16) | Identifier bits 16 down to 1 |

## Verification
The bench drives sample levels of exactly 127 and 126. A slicer with a threshold off by one would lose every edge and report nothing. Some frames use cycles of 7, 9 and 11 samples, so a classifier that matches only exact periods of 8 and 10 would decode those frames wrongly. One frame ends in a run of more than fifty short cycles. A design that clamps a long run to four symbols, instead of dropping it, would wrongly report that frame. Other cases cover an invalid symbol pair in the middle of a frame, an all-zero identifier, a reset between frames, and a stalled output: a design that keeps a stale identifier, reports zero, or drops data under back-pressure would show up as an extra, missing or changed report.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

  localparam int MARK_LEN = 6;
  localparam logic [MARK_LEN-1:0] MARK_PATTERN = 6'b111000;
  localparam int MAX_COPIES = 4;

  typedef logic [2:0] copies_t;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } frame_state_e;

  // Symbols produced by one finished run, given the divided run length.
  function automatic copies_t run_copies(input int unsigned k);
    if (k <= 1)               return copies_t'(1);
    else if (k <= MAX_COPIES) return copies_t'(k);
    else                      return copies_t'(0);
  endfunction

endpackage

// File: rtl/fsk_edge_classifier.sv
module fsk_edge_classifier #(
  parameter int DATA_W      = 8,
  parameter int SLICE_LEVEL = 127,
  parameter int SHORT_MAX   = 8,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_fire,
  input  logic [DATA_W-1:0] in_data,
  output logic              cls_valid,
  output logic              cls_fast
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_bit;
  logic             synced;
  logic [CNT_W-1:0] gap;
  logic             sliced;
  logic             rise;

  assign sliced = (in_data >= DATA_W'(SLICE_LEVEL));
  assign rise   = sliced & ~prev_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bit  <= 1'b1;
      synced    <= 1'b0;
      gap       <= CNT_W'(1);
      cls_valid <= 1'b0;
      cls_fast  <= 1'b0;
    end else begin
      cls_valid <= 1'b0;
      if (in_fire) begin
        prev_bit <= sliced;
        if (rise) begin
          synced    <= 1'b1;
          gap       <= CNT_W'(1);
          cls_valid <= synced;
          cls_fast  <= (gap <= CNT_W'(SHORT_MAX));
        end else if (gap != CNT_MAX) begin
          gap <= gap + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fsk_run_symbolizer.sv
module fsk_run_symbolizer
  import fsk_demod_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int FAST_DIV = 6,
  parameter int SLOW_DIV = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cls_valid,
  input  logic cls_fast,
  input  logic adv,
  output logic sym_valid,
  output logic sym_bit,
  output logic busy
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_active;
  logic             run_val;
  logic [CNT_W-1:0] run_cnt;
  copies_t          burst_left;
  logic             burst_val;

  logic [CNT_W:0]   cnt_p1;
  int unsigned      k_div;
  copies_t          copies;
  logic             closing;

  always_comb begin
    cnt_p1  = {1'b0, run_cnt} + (CNT_W+1)'(1);
    k_div   = run_val ? (32'(cnt_p1) / 32'(FAST_DIV))
                      : (32'(cnt_p1) / 32'(SLOW_DIV));
    copies  = run_copies(k_div);
    closing = cls_valid & run_active & (cls_fast != run_val);
  end

  assign busy      = (burst_left != '0);
  assign sym_valid = busy & adv;
  assign sym_bit   = burst_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_active <= 1'b0;
      run_val    <= 1'b0;
      run_cnt    <= '0;
      burst_left <= '0;
      burst_val  <= 1'b0;
    end else begin
      if (sym_valid) burst_left <= burst_left - 1'b1;
      if (cls_valid) begin
        if (!run_active) begin
          run_active <= 1'b1;
          run_val    <= cls_fast;
          run_cnt    <= CNT_W'(1);
        end else if (closing) begin
          burst_left <= copies;
          burst_val  <= run_val;
          run_val    <= cls_fast;
          run_cnt    <= CNT_W'(1);
        end else if (run_cnt != CNT_MAX) begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fsk_frame_decoder.sv
module fsk_frame_decoder
  import fsk_demod_pkg::*;
#(
  parameter int ID_W   = 64,
  parameter int CARD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid,
  input  logic              sym_bit,
  input  logic              o_ready,
  output logic              o_valid,
  output logic [ID_W-1:0]   o_id,
  output logic [CARD_W-1:0] o_card,
  output logic              stall,
  output logic [2:0]        win_fill
);

  frame_state_e         state;
  logic [MARK_LEN-1:0]  win;
  logic [2:0]           fill;
  logic [ID_W-1:0]      id;

  logic                 act;
  logic                 is_mark;
  logic [1:0]           pair;
  logic [2:0]           pop;
  logic [2:0]           fill_after;
  logic [2:0]           pos;
  logic [MARK_LEN-1:0]  nwin;
  logic [2:0]           nfill;

  assign stall    = o_valid & ~o_ready;
  assign win_fill = fill;

  always_comb begin
    act     = (fill == 3'(MARK_LEN)) & ~stall;
    is_mark = (win == MARK_PATTERN);
    pair    = win[MARK_LEN-1 -: 2];
    if (!act)                 pop = 3'd0;
    else if (is_mark)         pop = 3'(MARK_LEN);
    else if (state == ST_FRAME) pop = 3'd2;
    else                      pop = 3'd1;
    fill_after = fill - pop;
    pos        = 3'(MARK_LEN-1) - fill_after;
    nwin       = win << pop;
    if (sym_valid) nwin[pos] = sym_bit;
    nfill = fill_after + {2'b00, sym_valid};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      win     <= '0;
      fill    <= '0;
      id      <= '0;
      o_valid <= 1'b0;
      o_id    <= '0;
      o_card  <= '0;
    end else begin
      win  <= nwin;
      fill <= nfill;
      if (o_valid && o_ready) o_valid <= 1'b0;
      if (act) begin
        if (is_mark) begin
          if (id != '0) begin
            o_valid <= 1'b1;
            o_id    <= id;
            o_card  <= id[CARD_W:1];
          end
          id    <= '0;
          state <= ST_FRAME;
        end else if (state == ST_FRAME) begin
          case (pair)
            2'b10:   id <= {id[ID_W-2:0], 1'b0};
            2'b01:   id <= {id[ID_W-2:0], 1'b1};
            default: begin
              id    <= '0;
              state <= ST_HUNT;
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/fsk_tag_demod.sv
module fsk_tag_demod #(
  parameter int DATA_W      = 8,
  parameter int SLICE_LEVEL = 127,
  parameter int SHORT_MAX   = 8,
  parameter int CNT_W       = 8,
  parameter int FAST_DIV    = 6,
  parameter int SLOW_DIV    = 5,
  parameter int ID_W        = 64,
  parameter int CARD_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [ID_W-1:0]   o_id,
  output logic [CARD_W-1:0] o_card
);

  logic       in_fire;
  logic       cls_valid;
  logic       cls_fast;
  logic       sym_valid;
  logic       sym_bit;
  logic       sym_busy;
  logic       stall;
  logic [2:0] win_fill;

  assign s_ready = ~stall & ~sym_busy & ~cls_valid;
  assign in_fire = s_valid & s_ready;

  fsk_edge_classifier #(
    .DATA_W(DATA_W), .SLICE_LEVEL(SLICE_LEVEL),
    .SHORT_MAX(SHORT_MAX), .CNT_W(CNT_W)
  ) u_edge (
    .clk(clk), .rst(rst), .in_fire(in_fire), .in_data(s_data),
    .cls_valid(cls_valid), .cls_fast(cls_fast)
  );

  fsk_run_symbolizer #(
    .CNT_W(CNT_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
  ) u_run (
    .clk(clk), .rst(rst), .cls_valid(cls_valid), .cls_fast(cls_fast),
    .adv(~stall), .sym_valid(sym_valid), .sym_bit(sym_bit), .busy(sym_busy)
  );

  fsk_frame_decoder #(
    .ID_W(ID_W), .CARD_W(CARD_W)
  ) u_frame (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bit(sym_bit),
    .o_ready(o_ready), .o_valid(o_valid), .o_id(o_id), .o_card(o_card),
    .stall(stall), .win_fill(win_fill)
  );

endmodule

// File: rtl/fsk_tag_demod_checker.sv
module fsk_tag_demod_checker #(
  parameter int ID_W   = 64,
  parameter int CARD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              s_ready,
  input logic              o_valid,
  input logic              o_ready,
  input logic [ID_W-1:0]   o_id,
  input logic [CARD_W-1:0] o_card,
  input logic              cls_valid,
  input logic              sym_busy,
  input logic [2:0]        win_fill
);

  a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> o_valid);

  a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> ($stable(o_id) && $stable(o_card)));

  a_r8_input_blocked: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |-> !s_ready);

  a_r7_card_field: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_card == o_id[CARD_W:1]));

  a_r7_nonzero_id: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_id != '0));

  a_r4_no_burst_overlap: assert property (@(posedge clk) disable iff (rst)
    cls_valid |-> !sym_busy);

  a_r5_window_bound: assert property (@(posedge clk) disable iff (rst)
    win_fill <= 3'd6);

  a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!o_valid && s_ready));

endmodule

bind fsk_tag_demod fsk_tag_demod_checker #(.ID_W(ID_W), .CARD_W(CARD_W)) u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .o_valid(o_valid),
  .o_ready(o_ready), .o_id(o_id), .o_card(o_card), .cls_valid(cls_valid),
  .sym_busy(sym_busy), .win_fill(win_fill)
);

// File: tb/fsk_tag_demod_bench.sv
module fsk_tag_demod_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        s_valid;
  logic        s_ready;
  logic [7:0]  s_data;
  logic        o_valid;
  logic        o_ready;
  logic [63:0] o_id;
  logic [15:0] o_card;

  always #2 clk = ~clk;

  fsk_tag_demod u_fsk_tag_demod (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_id(o_id), .o_card(o_card)
  );

  typedef struct packed {
    logic [43:0] tag;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [3:0]  pf;
    logic [3:0]  ps;
  } row_t;

  localparam row_t ROWS [5] = '{
    '{44'h0AB_CDEF_1234, 8'd200, 8'd20,  4'd8, 4'd10},
    '{44'hFFF_FFFF_FFFF, 8'd127, 8'd126, 4'd8, 4'd10},
    '{44'h000_0000_0000, 8'd200, 8'd20,  4'd8, 4'd10},
    '{44'h123_4567_89AB, 8'd255, 8'd0,   4'd7, 4'd9},
    '{44'h800_0000_0001, 8'd200, 8'd20,  4'd8, 4'd11}
  };

  int          n_checks = 0;
  int          n_errors = 0;
  string       cur_req  = "R9";
  logic [63:0] exp_id [32];
  int          exp_wr = 0;
  int          exp_rd = 0;
  logic [7:0]  lv_hi = 8'd200, lv_lo = 8'd20;
  int          pf = 8, ps = 10;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push_exp(input logic [43:0] tag);
    if (tag != '0) begin
      exp_id[exp_wr] = {20'd0, tag};
      exp_wr++;
    end
  endtask

  // Called at a negative edge; returns at the negative edge after acceptance.
  task automatic send_sample(input logic [7:0] v);
    s_data  = v;
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cyc(input int per);
    for (int k = 0; k < per; k++)
      send_sample((k < ((per <= 8) ? 2 : 3)) ? lv_hi : lv_lo);
  endtask

  task automatic fast(input int n);
    for (int j = 0; j < n; j++) cyc(pf);
  endtask

  task automatic slow(input int n);
    for (int j = 0; j < n; j++) cyc(ps);
  endtask

  // Marker, a leading 0 bit, then 44 tag bits MSB first; bit index bad is broken.
  task automatic send_frame(input logic [43:0] tag, input int bad);
    fast(18); slow(15); fast(6); slow(5);
    for (int i = 43; i >= 0; i--) begin
      if (i == bad) fast(12);
      else if (tag[i]) begin slow(5); fast(6); end
      else begin fast(6); slow(5); end
    end
  endtask

  task automatic set_std();
    lv_hi = 8'd200; lv_lo = 8'd20; pf = 8; ps = 10;
  endtask

  task automatic settle(input string req);
    s_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(exp_rd == exp_wr, req, 64'(exp_rd), 64'(exp_wr));
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // Output monitor: every handshake must match the next expected identifier.
  always @(negedge clk) begin
    if (!rst && o_valid && o_ready) begin
      if (exp_rd >= exp_wr) begin
        check(1'b0, {cur_req, " R7 unexpected report"}, o_id, 64'd0);
      end else begin
        check(o_id == exp_id[exp_rd], {cur_req, " R6 identifier"}, o_id, exp_id[exp_rd]);
        check(o_card == exp_id[exp_rd][16:1], "R7 card field",
              64'(o_card), 64'(exp_id[exp_rd][16:1]));
        exp_rd++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; s_valid = 1'b0; s_data = '0; o_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(o_valid == 1'b0, "R9 reset o_valid", 64'(o_valid), 64'd0);
    check(s_ready == 1'b1, "R9 reset s_ready", 64'(s_ready), 64'd1);

    // Vector table: each frame is reported when the next marker arrives.
    for (int r = 0; r < 5; r++) begin
      case (r)
        1: cur_req = "R1";
        2: cur_req = "R7";
        3: cur_req = "R2";
        default: cur_req = "R3";
      endcase
      lv_hi = ROWS[r].hi; lv_lo = ROWS[r].lo;
      pf = int'(ROWS[r].pf); ps = int'(ROWS[r].ps);
      push_exp(ROWS[r].tag);
      send_frame(ROWS[r].tag, -1);
    end
    set_std();
    cur_req = "R5";
    send_frame('0, -1);
    settle("R5 table reports");

    // R6: an invalid pair inside a frame aborts and clears the identifier.
    cur_req = "R6";
    send_frame(44'h333_3333_3333, 42);
    push_exp(44'h06E_1234_5678);
    send_frame(44'h06E_1234_5678, -1);
    send_frame('0, -1);
    settle("R6 abort");

    // R4: an overlong short run emits nothing, which breaks frame L and the marker after it.
    cur_req = "R4";
    send_frame(44'h00F_0000_000F, -1);
    fast(30);
    send_frame(44'h0F0_F0F0_F0F0, -1);
    push_exp(44'hA5A_5A5A_5A5A);
    send_frame(44'hA5A_5A5A_5A5A, -1);
    send_frame('0, -1);
    settle("R4 long run");

    // R8: output back-pressure.
    cur_req = "R8";
    o_ready = 1'b0;
    push_exp(44'h3C3_0F0F_1E2D);
    fork
      begin
        send_frame(44'h3C3_0F0F_1E2D, -1);
        send_frame('0, -1);
      end
      begin
        while (!o_valid) @(negedge clk);
        for (int h = 0; h < 6; h++) begin
          @(negedge clk);
          check(o_valid && (o_id == 64'h3C3_0F0F_1E2D), "R8 hold", o_id, 64'h3C3_0F0F_1E2D);
          check(!s_ready, "R8 input stalled", 64'(s_ready), 64'd0);
        end
        o_ready = 1'b1;
      end
    join
    settle("R8 released");

    // R9: reset discards a collected identifier.
    cur_req = "R9";
    send_frame(44'h555_AAAA_5555, -1);
    s_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(o_valid == 1'b0, "R9 after reset o_valid", 64'(o_valid), 64'd0);
    check(s_ready == 1'b1, "R9 after reset s_ready", 64'(s_ready), 64'd1);
    send_frame('0, -1);
    settle("R9 no stale report");
    push_exp(44'h7E1_8001_2469);
    send_frame(44'h7E1_8001_2469, -1);
    send_frame('0, -1);
    settle("R9 resumed");

    finished = 1;
    summary();
    $finish;
  end

endmodule